// File: doc/BRIEF.md
# Sequential Unsigned Multiply-Divide Unit

This block is a multicycle arithmetic engine for unsigned integers. A one-cycle start pulse presents two operands and a two-bit operation code. The unit then runs an iterative datapath and raises done for exactly one cycle. It supports two operand sizes, narrow and wide, for each of multiplication and division. Each of the four modes finishes after its own fixed number of cycles, so a sequencer can schedule around it without polling.

Multiplication returns the product on the result port. Division returns the quotient, zero-extended, on the result port and the remainder on the remainder port. A zero divisor does not stall or trap. The unit completes in the normal number of cycles, raises a flag and returns a defined pattern. The result, remainder and flag change only in the cycle in which done goes high, and they hold until the next completion.

Top module: `muldiv_seq`

## Requirements
- R1: With op = 2'b00 the unit multiplies opa[15:0] by opb[7:0]. Bits opa[23:16] and opb[15:8] have no effect. done is high in the 5th cycle after the cycle in which start was accepted.
- R2: With op = 2'b01 the unit multiplies opa[23:0] by opb[15:0] into a 40-bit product. done is high in the 12th cycle after acceptance.
- R3: With op = 2'b10 the unit divides opa[15:0] by opb[7:0]. It returns a 16-bit quotient and an 8-bit remainder, and the upper operand bits have no effect. done comes 8 cycles after acceptance.
- R4: With op = 2'b11 the unit divides opa[23:0] by opb[15:0]. It returns a 24-bit quotient and a 16-bit remainder. done comes 12 cycles after acceptance.
- R5: Bit 1 of op selects division (1) or multiplication (0). Bit 0 selects the wide (1) or narrow (0) operand size.
- R6: A division whose divisor is zero sets div_zero and returns a quotient of all ones at the dividend width. The remainder is the low divisor-width bits of the dividend, and done comes at the mode's normal latency. div_zero is low after every other operation.
- R7: done is high for exactly one cycle per accepted start. result, remainder and div_zero change only in a done cycle and otherwise hold their values.
- R8: A start while busy is high is ignored and produces no extra done. busy is low in the done cycle, so a start in that cycle is accepted.
- R9: After reset, busy, done, div_zero, result and remainder are all zero.
- R10: After a multiplication, remainder is zero. Result bits above the mode's product or quotient width are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, accepted when busy is low |
| op | input | 2 | Operation code: bit 1 divide, bit 0 wide |
| opa | input | 24 | Multiplicand or dividend |
| opb | input | 16 | Multiplier or divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 40 | Product or zero-extended quotient |
| remainder | output | 16 | Division remainder, zero after multiplication |
| div_zero | output | 1 | Last division had a zero divisor |

## Verification
The hardest situation to reach from the ports is a new request arriving exactly in the done cycle of the previous one. The stimulus reaches it by keeping the driver waiting only on busy, so every back-to-back request lands in that cycle. A second hard case is a start pulse held during a running operation with a different opcode and a zero divisor. The bench shows that no extra completion appears and that the running result is not disturbed. Narrow-mode requests carry random junk in the ignored upper operand bits, and zero divisors are mixed into both division widths.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

   typedef enum logic [1:0] {
      OP_MUL_N = 2'b00,
      OP_MUL_W = 2'b01,
      OP_DIV_N = 2'b10,
      OP_DIV_W = 2'b11
   } md_op_e;

   function automatic logic op_is_div(md_op_e o);
      return o[1];
   endfunction

   function automatic logic op_is_wide(md_op_e o);
      return o[0];
   endfunction

endpackage

// File: rtl/md_sequencer.sv
module md_sequencer #(
   parameter int CW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          accept,
   input  logic [CW-1:0] lat_m1,
   input  logic [CW-1:0] iters,
   output logic          busy,
   output logic          step_en,
   output logic          last
);

   logic [CW-1:0] cnt_r;
   logic [CW-1:0] itl_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         cnt_r <= '0;
         itl_r <= '0;
      end else if (accept) begin
         busy  <= 1'b1;
         cnt_r <= lat_m1;
         itl_r <= iters;
      end else if (busy) begin
         if (itl_r != '0) itl_r <= itl_r - 1'b1;
         if (cnt_r == '0) busy <= 1'b0;
         else             cnt_r <= cnt_r - 1'b1;
      end
   end

   assign step_en = busy && (itl_r != '0);
   assign last    = busy && (cnt_r == '0);

   // every datapath iteration finishes no later than the final cycle (R4)
   p_iter_fit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      last |-> (itl_r <= CW'(1)));

endmodule

// File: rtl/md_mul_step.sv
module md_mul_step #(
   parameter int PW    = 40,
   parameter int BW    = 16,
   parameter int MSTEP = 2
) (
   input  logic [PW-1:0] acc_i,
   input  logic [PW-1:0] mc_i,
   input  logic [BW-1:0] mp_i,
   output logic [PW-1:0] acc_o,
   output logic [PW-1:0] mc_o,
   output logic [BW-1:0] mp_o
);

   logic [PW-1:0] part;

   if (MSTEP == 2) begin : g_radix4
      logic [PW-1:0] mc_x3;
      assign mc_x3 = mc_i + (mc_i << 1);
      always_comb begin
         case (mp_i[1:0])
            2'd0:    part = '0;
            2'd1:    part = mc_i;
            2'd2:    part = mc_i << 1;
            default: part = mc_x3;
         endcase
      end
   end else begin : g_bitsum
      always_comb begin
         part = '0;
         for (int i = 0; i < MSTEP; i++) begin
            if (mp_i[i]) part = part + (mc_i << i);
         end
      end
   end

   assign acc_o = acc_i + part;
   assign mc_o  = mc_i << MSTEP;
   assign mp_o  = mp_i >> MSTEP;

endmodule

// File: rtl/md_div_step.sv
module md_div_step #(
   parameter int AW    = 24,
   parameter int BW    = 16,
   parameter int DSTEP = 2
) (
   input  logic [BW-1:0] rem_i,
   input  logic [AW-1:0] q_i,
   input  logic [BW-1:0] dsr_i,
   output logic [BW-1:0] rem_o,
   output logic [AW-1:0] q_o
);

   logic [BW-1:0] r_s [DSTEP+1];
   logic [AW-1:0] q_s [DSTEP+1];

   assign r_s[0] = rem_i;
   assign q_s[0] = q_i;

   for (genvar k = 0; k < DSTEP; k++) begin : g_stage
      logic [BW:0]   r_ext;
      logic          ge;
      logic [BW-1:0] diff;
      assign r_ext      = {r_s[k], q_s[k][AW-1]};
      assign ge         = r_ext >= {1'b0, dsr_i};
      assign diff       = r_ext[BW-1:0] - dsr_i;
      assign r_s[k+1]   = ge ? diff : r_ext[BW-1:0];
      assign q_s[k+1]   = {q_s[k][AW-2:0], ge};
   end

   assign rem_o = r_s[DSTEP];
   assign q_o   = q_s[DSTEP];

endmodule

// File: rtl/muldiv_seq.sv
module muldiv_seq
   import muldiv_pkg::*;
#(
   parameter int AW     = 24,
   parameter int BW     = 16,
   parameter int AN     = 16,
   parameter int BN     = 8,
   parameter int MSTEP  = 2,
   parameter int DSTEP  = 2,
   parameter int LAT_MN = 5,
   parameter int LAT_MW = 12,
   parameter int LAT_DN = 8,
   parameter int LAT_DW = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [1:0]      op,
   input  logic [AW-1:0]   opa,
   input  logic [BW-1:0]   opb,
   output logic            busy,
   output logic            done,
   output logic [AW+BW-1:0] result,
   output logic [BW-1:0]   remainder,
   output logic            div_zero
);

   localparam int PW    = AW + BW;
   localparam int IT_MN = BN / MSTEP;
   localparam int IT_MW = BW / MSTEP;
   localparam int IT_DN = AN / DSTEP;
   localparam int IT_DW = AW / DSTEP;
   localparam int LSUM  = LAT_MN + LAT_MW + LAT_DN + LAT_DW;
   localparam int CW    = $clog2(LSUM + 2);
   localparam logic [AW-1:0] A_MASK_N = {AW{1'b1}} >> (AW - AN);
   localparam logic [BW-1:0] B_MASK_N = {BW{1'b1}} >> (BW - BN);

   // elaboration-time parameter checks
   if (AN > AW || BN > BW || BW > AW) begin : g_bad_width
      $error("muldiv_seq: narrow widths must not exceed wide widths, divisor not wider than dividend");
   end
   if ((BN % MSTEP) != 0 || (BW % MSTEP) != 0 || MSTEP < 1) begin : g_bad_mstep
      $error("muldiv_seq: multiplier widths must be multiples of MSTEP");
   end
   if ((AN % DSTEP) != 0 || (AW % DSTEP) != 0 || DSTEP < 1) begin : g_bad_dstep
      $error("muldiv_seq: dividend widths must be multiples of DSTEP");
   end
   if (LAT_MN < IT_MN || LAT_MW < IT_MW || LAT_DN < IT_DN || LAT_DW < IT_DW) begin : g_bad_lat
      $error("muldiv_seq: a latency is shorter than its iteration count");
   end

   md_op_e          op_in;
   logic            accept;
   logic            wide_in;
   logic [AW-1:0]   a_eff;
   logic [BW-1:0]   b_eff;
   logic [CW-1:0]   lat_m1;
   logic [CW-1:0]   iters;
   logic            step_en;
   logic            last;

   md_op_e          op_r;
   logic [PW-1:0]   acc_r, mc_r;
   logic [BW-1:0]   mp_r;
   logic [BW-1:0]   rem_r, dsr_r, dvd_r;
   logic [AW-1:0]   q_r;

   logic [PW-1:0]   acc_s, mc_s;
   logic [BW-1:0]   mp_s, rem_s;
   logic [AW-1:0]   q_s;

   logic [PW-1:0]   acc_f;
   logic [BW-1:0]   rem_f;
   logic [AW-1:0]   q_f;
   logic [PW-1:0]   res_fin;
   logic [BW-1:0]   rem_fin;
   logic            dz_fin;

   logic            done_q, dz_q;
   logic [PW-1:0]   result_q;
   logic [BW-1:0]   rem_q;

   assign op_in   = md_op_e'(op);
   assign wide_in = op_is_wide(op_in);
   assign a_eff   = wide_in ? opa : (opa & A_MASK_N);
   assign b_eff   = wide_in ? opb : (opb & B_MASK_N);
   assign accept  = start && !busy;

   always_comb begin
      case (op_in)
         OP_MUL_W: begin lat_m1 = CW'(LAT_MW - 1); iters = CW'(IT_MW); end
         OP_DIV_N: begin lat_m1 = CW'(LAT_DN - 1); iters = CW'(IT_DN); end
         OP_DIV_W: begin lat_m1 = CW'(LAT_DW - 1); iters = CW'(IT_DW); end
         default:  begin lat_m1 = CW'(LAT_MN - 1); iters = CW'(IT_MN); end
      endcase
   end

   md_sequencer #(.CW(CW)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .accept  (accept),
      .lat_m1  (lat_m1),
      .iters   (iters),
      .busy    (busy),
      .step_en (step_en),
      .last    (last)
   );

   md_mul_step #(.PW(PW), .BW(BW), .MSTEP(MSTEP)) u_mul (
      .acc_i (acc_r),
      .mc_i  (mc_r),
      .mp_i  (mp_r),
      .acc_o (acc_s),
      .mc_o  (mc_s),
      .mp_o  (mp_s)
   );

   md_div_step #(.AW(AW), .BW(BW), .DSTEP(DSTEP)) u_div (
      .rem_i (rem_r),
      .q_i   (q_r),
      .dsr_i (dsr_r),
      .rem_o (rem_s),
      .q_o   (q_s)
   );

   // values after the current cycle's iteration, used at completion
   assign acc_f  = step_en ? acc_s : acc_r;
   assign rem_f  = step_en ? rem_s : rem_r;
   assign q_f    = step_en ? q_s   : q_r;
   assign dz_fin = op_is_div(op_r) && (dsr_r == '0);

   always_comb begin
      if (!op_is_div(op_r)) begin
         res_fin = acc_f;
         rem_fin = '0;
      end else if (dz_fin) begin
         res_fin = PW'(op_is_wide(op_r) ? {AW{1'b1}} : A_MASK_N);
         rem_fin = op_is_wide(op_r) ? dvd_r : (dvd_r & B_MASK_N);
      end else begin
         res_fin = PW'(op_is_wide(op_r) ? q_f : (q_f & A_MASK_N));
         rem_fin = rem_f;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_r     <= OP_MUL_N;
         acc_r    <= '0;
         mc_r     <= '0;
         mp_r     <= '0;
         rem_r    <= '0;
         dsr_r    <= '0;
         dvd_r    <= '0;
         q_r      <= '0;
         done_q   <= 1'b0;
         dz_q     <= 1'b0;
         result_q <= '0;
         rem_q    <= '0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            op_r  <= op_in;
            acc_r <= '0;
            mc_r  <= PW'(a_eff);
            mp_r  <= b_eff;
            rem_r <= '0;
            dsr_r <= b_eff;
            dvd_r <= a_eff[BW-1:0];
            q_r   <= wide_in ? a_eff : (a_eff << (AW - AN));
         end else if (step_en) begin
            if (op_is_div(op_r)) begin
               rem_r <= rem_s;
               q_r   <= q_s;
            end else begin
               acc_r <= acc_s;
               mc_r  <= mc_s;
               mp_r  <= mp_s;
            end
         end
         if (last) begin
            done_q   <= 1'b1;
            result_q <= res_fin;
            rem_q    <= rem_fin;
            dz_q     <= dz_fin;
         end
      end
   end

   assign done      = done_q;
   assign result    = result_q;
   assign remainder = rem_q;
   assign div_zero  = dz_q;

   // cycle counter used only by the latency assertions
   logic [CW-1:0] chk_age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       chk_age <= '0;
      else if (accept)  chk_age <= '0;
      else if (busy)    chk_age <= chk_age + 1'b1;
   end

   p_lat_mn_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (done && op_r == OP_MUL_N) |-> chk_age == CW'(LAT_MN));
   p_lat_mw_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (done && op_r == OP_MUL_W) |-> chk_age == CW'(LAT_MW));
   p_lat_dn_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && op_r == OP_DIV_N) |-> chk_age == CW'(LAT_DN));
   p_lat_dw_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && op_r == OP_DIV_W) |-> chk_age == CW'(LAT_DW));
   p_rem_below_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && op_is_div(op_r) && dsr_r != '0) |-> rem_r < dsr_r);
   p_divz_quot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && div_zero) |-> (result == PW'(op_is_wide(op_r) ? {AW{1'b1}} : A_MASK_N)));
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(result) && $stable(remainder) && $stable(div_zero)));
   p_hold_op_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !last) |=> (busy && $stable(op_r)));
   p_mul_rem_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !op_is_div(op_r)) |-> (remainder == '0 && !div_zero));

endmodule

// File: tb/sim_muldiv_seq.sv
module sim_muldiv_seq;

   localparam int CLK_PERIOD = 10;

   typedef struct {
      logic [1:0]  op;
      logic [39:0] res;
      logic [15:0] rem;
      logic        dz;
      int          due;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  op = 2'b00;
   logic [23:0] opa = '0;
   logic [15:0] opb = '0;
   logic        busy, done, div_zero;
   logic [39:0] result;
   logic [15:0] remainder;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   exp_t sbq[$];

   muldiv_seq u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .op        (op),
      .opa       (opa),
      .opb       (opb),
      .busy      (busy),
      .done      (done),
      .result    (result),
      .remainder (remainder),
      .div_zero  (div_zero)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input logic ok, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", what, act, exp, cyc);
      end
   endtask

   function automatic int lat_of(input logic [1:0] o);
      case (o)
         2'b00:   return 5;
         2'b01:   return 12;
         2'b10:   return 8;
         default: return 12;
      endcase
   endfunction

   function automatic string tag_of(input logic [1:0] o);
      case (o)
         2'b00:   return "R1";
         2'b01:   return "R2";
         2'b10:   return "R3";
         default: return "R4";
      endcase
   endfunction

   function automatic exp_t model(input logic [1:0] o, input logic [23:0] a, input logic [15:0] b);
      exp_t e;
      logic [23:0] aa;
      logic [15:0] bb;
      aa = o[0] ? a : {8'h00, a[15:0]};
      bb = o[0] ? b : {8'h00, b[7:0]};
      e.op = o;
      e.due = 0;
      if (!o[1]) begin
         e.res = 40'(aa) * 40'(bb);
         e.rem = '0;
         e.dz  = 1'b0;
      end else if (bb == 16'h0) begin
         e.dz  = 1'b1;
         e.res = o[0] ? 40'hFF_FFFF : 40'h00_FFFF;
         e.rem = o[0] ? a[15:0] : {8'h00, a[7:0]};
      end else begin
         e.dz  = 1'b0;
         e.res = 40'(aa / 24'(bb));
         e.rem = 16'(aa % 24'(bb));
      end
      return e;
   endfunction

   // driver: waits only on busy, so a follow-on request lands in the done cycle (R8)
   task automatic do_op(input logic [1:0] o, input logic [23:0] a, input logic [15:0] b);
      exp_t e;
      while (busy) @(negedge clk);
      e = model(o, a, b);
      e.due = cyc + 1 + lat_of(o);
      sbq.push_back(e);
      start = 1'b1;
      op    = o;
      opa   = a;
      opb   = b;
      @(negedge clk);
      start = 1'b0;
      opa   = 24'($urandom);
      opb   = 16'($urandom);
   endtask

   // monitor: compares each completion against the scoreboard
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (sbq.size() == 0) begin
            chk(1'b0, "R8 done with no accepted request", 64'(done), 64'(0));
         end else begin
            exp_t e;
            string t;
            e = sbq.pop_front();
            t = tag_of(e.op);
            chk(cyc == e.due, {t, " latency"}, 64'(cyc), 64'(e.due));
            chk(result == e.res, {t, "/R5 result"}, 64'(result), 64'(e.res));
            chk(remainder == e.rem, {t, (e.op[1] ? "/R6 remainder" : "/R10 remainder")},
                64'(remainder), 64'(e.rem));
            chk(div_zero == e.dz, "R6 div_zero flag", 64'(div_zero), 64'(e.dz));
         end
      end
   end

   task automatic drain();
      int n = 0;
      @(negedge clk);
      while ((sbq.size() != 0 || busy) && n < 100) begin
         @(negedge clk);
         n++;
      end
      chk(sbq.size() == 0, "R7 all requests completed", 64'(sbq.size()), 64'(0));
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [39:0] h_res;
      logic [15:0] h_rem;
      logic        h_dz;
      repeat (4) @(negedge clk);
      // R9 reset state
      chk(busy == 1'b0 && done == 1'b0, "R9 busy/done in reset", 64'({busy, done}), 64'(0));
      rst_n = 1'b1;
      @(negedge clk);
      chk(result == '0 && remainder == '0, "R9 outputs after reset", 64'(result), 64'(0));
      chk(div_zero == 1'b0 && busy == 1'b0, "R9 flags after reset", 64'({div_zero, busy}), 64'(0));

      // directed corners, R1-style narrow ops carry junk in ignored upper bits
      do_op(2'b00, 24'hAB_FFFF, 16'h77FF);   // R1
      do_op(2'b01, 24'hFF_FFFF, 16'hFFFF);   // R2
      do_op(2'b10, 24'h5A_FFFF, 16'hC301);   // R3 divisor 1
      do_op(2'b10, 24'h00_0005, 16'h00F0);   // R3 divisor above dividend
      do_op(2'b11, 24'hFF_FFFF, 16'hFFFF);   // R4
      do_op(2'b11, 24'h00_0000, 16'h1234);   // R4 zero dividend
      do_op(2'b10, 24'h12_3456, 16'h0100);   // R6 narrow, low byte of divisor zero
      do_op(2'b11, 24'h98_7654, 16'h0000);   // R6 wide
      do_op(2'b00, 24'h00_0000, 16'h00FF);   // R1 zero product
      drain();

      // R8: start held during a running wide multiply is ignored
      do_op(2'b01, 24'h12_3456, 16'hABCD);
      start = 1'b1;
      op    = 2'b10;
      opa   = 24'h00_0099;
      opb   = 16'h0000;
      @(negedge clk);
      @(negedge clk);
      start = 1'b0;
      drain();

      // R7: outputs hold while idle even as inputs change
      h_res = result;
      h_rem = remainder;
      h_dz  = div_zero;
      for (int k = 0; k < 4; k++) begin
         opa = 24'($urandom);
         opb = 16'($urandom);
         op  = 2'($urandom);
         @(negedge clk);
      end
      chk(result == h_res && remainder == h_rem && div_zero == h_dz,
          "R7 outputs hold while idle", 64'(result), 64'(h_res));
      chk(done == 1'b0, "R7 done low while idle", 64'(done), 64'(0));

      // random mix, back-to-back in done cycles and occasional gaps
      for (int i = 0; i < 300; i++) begin
         logic [1:0]  o;
         logic [23:0] a;
         logic [15:0] b;
         o = 2'($urandom);
         a = 24'($urandom);
         b = 16'($urandom);
         if ($urandom % 8 == 0) b = (o[0] ? 16'h0000 : {b[15:8], 8'h00});
         if ($urandom % 6 == 0) a = 24'hFF_FFFF;
         if ($urandom % 5 == 0) repeat (1 + $urandom % 3) @(negedge clk);
         do_op(o, a, b);
      end
      drain();
      finish_run();
   end

endmodule